// File: doc/BRIEF.md
# Two-Port Parallel Interface Register File

This block is the processor-side register file of an adapter with two 8-bit parallel ports, A and B. A 2-bit location select picks one of four locations. Each port has a data location and a control location. The data location is shared between that port's output register and its direction register, and bit 2 of the port's control register chooses which of the two the location reaches. A read of an output register returns a per-bit merge: bits configured as outputs come from the latch and bits configured as inputs come from the pins.

The handshake units beside this block detect edges on the control lines and generate strobes on them. Those units hand this block two pending flags per port. The block places the flags in the upper bits of a control read and combines them with the enable bits into one interrupt line per port. In the other direction, the block gives the handshake units a one-cycle pulse on every output-register read and every output-register write. The read pulse also tells them to clear both flags of that port.

Accesses are single-cycle strobes qualified by a chip select, and the block never stalls the processor. There is no back-pressure: each strobe is accepted in the cycle it is presented. Read data is combinational from the current register state. A write takes effect at the next clock edge.

Top module: `ppi_regfile`

## Requirements
- R1: After reset every register is zero: both ports drive 0 with direction 0 (all inputs), both interrupts are low, and a read of either data location returns the direction register, which is 0x00.
- R2: Location select encoding is 0 = port A data, 1 = port B data, 2 = port A control, 3 = port B control. Control bit 2 set routes the data location to the output register; clear routes it to the direction register.
- R3: An output-register read returns (output AND direction) OR (pins AND NOT direction), bit by bit.
- R4: The output register keeps the whole written byte, and the pin drive is always output AND direction, so a later direction write changes the drive without rewriting the output register.
- R5: A control write stores only bits 5..0. Bits 7 and 6 of the written byte are discarded.
- R6: A control read returns bit 7 equal to flag 1, and bit 6 equal to flag 2 only while control bit 5 is 0 (line 2 is an input); otherwise bit 6 is 0. Bits 5..0 read back as stored.
- R7: An output-register read gives that port's read pulse (which also clears its flags) in the same cycle. A direction-register read gives no pulse.
- R8: An output-register write gives that port's write pulse in the same cycle. A direction-register write gives no pulse.
- R9: A port's interrupt is (flag 1 AND control bit 0) OR (flag 2 AND control bit 3 AND control bit 5 clear).
- R10: Without chip select, writes are ignored, no pulse fires, and the read bus is 0x00. It is also 0x00 whenever no read strobe is present.
- R11: A read and a write to the same location in one cycle return the pre-write contents. The written value is visible from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| reg_sel | input | 2 | Location select |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin levels |
| pb_in | input | 8 | Port B pin levels |
| pa_drive | output | 8 | Port A driven value |
| pa_dir | output | 8 | Port A direction (1 = output) |
| pb_drive | output | 8 | Port B driven value |
| pb_dir | output | 8 | Port B direction (1 = output) |
| a_flag1 | input | 1 | Port A line-1 pending flag |
| a_flag2 | input | 1 | Port A line-2 pending flag |
| b_flag1 | input | 1 | Port B line-1 pending flag |
| b_flag2 | input | 1 | Port B line-2 pending flag |
| a_ctrl | output | 6 | Port A stored control bits |
| b_ctrl | output | 6 | Port B stored control bits |
| a_rd_pulse | output | 1 | Port A output read (flag clear) |
| a_wr_pulse | output | 1 | Port A output write |
| b_rd_pulse | output | 1 | Port B output read (flag clear) |
| b_wr_pulse | output | 1 | Port B output write |
| irq_a | output | 1 | Port A interrupt |
| irq_b | output | 1 | Port B interrupt |

## Verification
A read and a write to the same output register can coincide in one cycle. In that cycle the combinational read path and the registered write path operate together, and both handshake pulses fire at once. The bench raises both strobes in a single cycle at port A's data location. It checks that the read bus shows the old merged value and that both port A pulses are high while port B's stay low. It then reads again and expects the newly written byte.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
  // control register bit positions (neighbouring handshake units decode these)
  localparam int CTL_W      = 6;
  localparam int CTL_IE1    = 0;
  localparam int CTL_EDGE1  = 1;
  localparam int CTL_OSEL   = 2;
  localparam int CTL_IE2    = 3;
  localparam int CTL_C2OUT  = 5;
  localparam int STAT_W     = 8;

  typedef enum logic [1:0] {
    LOC_DATA_A = 2'd0,
    LOC_DATA_B = 2'd1,
    LOC_CTRL_A = 2'd2,
    LOC_CTRL_B = 2'd3
  } loc_e;
endpackage

// File: rtl/ppi_loc_decode.sv
module ppi_loc_decode #(
  parameter int NPORT = 2,
  localparam int SELW = $clog2(2 * NPORT)
) (
  input  logic             cs,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [SELW-1:0]  reg_sel,
  output logic [NPORT-1:0] data_rd,
  output logic [NPORT-1:0] data_wr,
  output logic [NPORT-1:0] ctrl_wr,
  output logic             rd_active
);
  // data locations occupy 0..NPORT-1, control locations NPORT..2*NPORT-1
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam logic [SELW-1:0] DLOC = SELW'(p);
    localparam logic [SELW-1:0] CLOC = SELW'(NPORT + p);
    assign data_rd[p] = cs && rd_en && (reg_sel == DLOC);
    assign data_wr[p] = cs && wr_en && (reg_sel == DLOC);
    assign ctrl_wr[p] = cs && wr_en && (reg_sel == CLOC);
  end
  assign rd_active = cs && rd_en;
endmodule

// File: rtl/ppi_port_unit.sv
module ppi_port_unit
  import ppi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_rd,
  input  logic              data_wr,
  input  logic              ctrl_wr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     pins,
  input  logic              flag1,
  input  logic              flag2,
  output logic [CTL_W-1:0]  ctrl,
  output logic [DW-1:0]     dir,
  output logic [DW-1:0]     drive,
  output logic [DW-1:0]     data_view,
  output logic [STAT_W-1:0] ctrl_view,
  output logic              irq,
  output logic              rd_pulse,
  output logic              wr_pulse
);
  logic [DW-1:0] out_q;
  logic          osel;
  logic          c2_in;

  assign osel  = ctrl[CTL_OSEL];
  assign c2_in = ~ctrl[CTL_C2OUT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q <= '0;
      dir   <= '0;
      ctrl  <= '0;
    end else begin
      if (data_wr) begin
        if (osel) out_q <= wdata;
        else      dir   <= wdata;
      end
      if (ctrl_wr) ctrl <= wdata[CTL_W-1:0];
    end
  end

  // the latch is kept unmasked; masking happens on the way out
  assign drive     = out_q & dir;
  assign data_view = osel ? (drive | (pins & ~dir)) : dir;
  assign ctrl_view = {flag1, flag2 & c2_in, ctrl};
  assign irq       = (flag1 & ctrl[CTL_IE1]) | (flag2 & ctrl[CTL_IE2] & c2_in);
  assign rd_pulse  = data_rd & osel;
  assign wr_pulse  = data_wr & osel;
endmodule

// File: rtl/ppi_read_mux.sv
module ppi_read_mux
  import ppi_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NPORT = 2,
  localparam int SELW = $clog2(2 * NPORT)
) (
  input  logic              rd_active,
  input  logic [SELW-1:0]   reg_sel,
  input  logic [DW-1:0]     data_view [NPORT],
  input  logic [STAT_W-1:0] ctrl_view [NPORT],
  output logic [DW-1:0]     rdata
);
  always_comb begin
    rdata = '0;
    if (rd_active) begin
      for (int p = 0; p < NPORT; p++) begin
        if (reg_sel == SELW'(p))         rdata = data_view[p];
        if (reg_sel == SELW'(NPORT + p)) rdata = DW'(ctrl_view[p]);
      end
    end
  end
endmodule

// File: rtl/ppi_regfile.sv
module ppi_regfile
  import ppi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [1:0]       reg_sel,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [DW-1:0]    pa_in,
  input  logic [DW-1:0]    pb_in,
  output logic [DW-1:0]    pa_drive,
  output logic [DW-1:0]    pa_dir,
  output logic [DW-1:0]    pb_drive,
  output logic [DW-1:0]    pb_dir,
  input  logic             a_flag1,
  input  logic             a_flag2,
  input  logic             b_flag1,
  input  logic             b_flag2,
  output logic [CTL_W-1:0] a_ctrl,
  output logic [CTL_W-1:0] b_ctrl,
  output logic             a_rd_pulse,
  output logic             a_wr_pulse,
  output logic             b_rd_pulse,
  output logic             b_wr_pulse,
  output logic             irq_a,
  output logic             irq_b
);
  localparam int NPORT = 2;

  logic [NPORT-1:0]  data_rd, data_wr, ctrl_wr;
  logic              rd_active;
  logic [DW-1:0]     pins      [NPORT];
  logic [DW-1:0]     dir       [NPORT];
  logic [DW-1:0]     drive     [NPORT];
  logic [DW-1:0]     data_view [NPORT];
  logic [STAT_W-1:0] ctrl_view [NPORT];
  logic [CTL_W-1:0]  ctrl      [NPORT];
  logic [NPORT-1:0]  flag1, flag2, irq, rd_pulse, wr_pulse;

  assign pins[0] = pa_in;
  assign pins[1] = pb_in;
  assign flag1   = {b_flag1, a_flag1};
  assign flag2   = {b_flag2, a_flag2};

  ppi_loc_decode #(.NPORT(NPORT)) dec_i (
    .cs(cs), .rd_en(rd_en), .wr_en(wr_en), .reg_sel(reg_sel),
    .data_rd(data_rd), .data_wr(data_wr), .ctrl_wr(ctrl_wr),
    .rd_active(rd_active)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_unit
    ppi_port_unit #(.DW(DW)) unit_i (
      .clk(clk), .rst_n(rst_n),
      .data_rd(data_rd[p]), .data_wr(data_wr[p]), .ctrl_wr(ctrl_wr[p]),
      .wdata(wdata), .pins(pins[p]),
      .flag1(flag1[p]), .flag2(flag2[p]),
      .ctrl(ctrl[p]), .dir(dir[p]), .drive(drive[p]),
      .data_view(data_view[p]), .ctrl_view(ctrl_view[p]),
      .irq(irq[p]), .rd_pulse(rd_pulse[p]), .wr_pulse(wr_pulse[p])
    );
  end

  ppi_read_mux #(.DW(DW), .NPORT(NPORT)) mux_i (
    .rd_active(rd_active), .reg_sel(reg_sel),
    .data_view(data_view), .ctrl_view(ctrl_view), .rdata(rdata)
  );

  assign pa_drive   = drive[0];
  assign pb_drive   = drive[1];
  assign pa_dir     = dir[0];
  assign pb_dir     = dir[1];
  assign a_ctrl     = ctrl[0];
  assign b_ctrl     = ctrl[1];
  assign irq_a      = irq[0];
  assign irq_b      = irq[1];
  assign a_rd_pulse = rd_pulse[0];
  assign b_rd_pulse = rd_pulse[1];
  assign a_wr_pulse = wr_pulse[0];
  assign b_wr_pulse = wr_pulse[1];
endmodule

// File: rtl/ppi_regfile_chk.sv
module ppi_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       rd_en,
  input logic       wr_en,
  input logic [1:0] reg_sel,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic [7:0] pa_drive,
  input logic [7:0] pa_dir,
  input logic       a_flag1,
  input logic       a_flag2,
  input logic [5:0] a_ctrl,
  input logic       a_rd_pulse,
  input logic       b_rd_pulse,
  input logic       a_wr_pulse,
  input logic       b_wr_pulse,
  input logic       irq_a
);
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && reg_sel == 2'd0 && !a_ctrl[2]) |=> (pa_dir == $past(wdata)));

  assert_out_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && reg_sel == 2'd0 && a_ctrl[2]) |=> (pa_drive == ($past(wdata) & pa_dir)));

  assert_ctrl_store_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && wr_en && reg_sel == 2'd2) |=> (a_ctrl == $past(wdata[5:0])));

  assert_status_bits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && rd_en && reg_sel == 2'd2) |->
      (rdata[7] == a_flag1 && rdata[6] == (a_flag2 && !a_ctrl[5]) && rdata[5:0] == a_ctrl));

  assert_irq_flag1_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (a_flag1 && a_ctrl[0]) |-> irq_a);

  assert_irq_source_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a |-> (a_flag1 || a_flag2));

  assert_idle_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |-> (rdata == 8'h00 && !a_rd_pulse && !b_rd_pulse && !a_wr_pulse && !b_wr_pulse));

  assert_one_port_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({a_rd_pulse, b_rd_pulse}));
endmodule

bind ppi_regfile ppi_regfile_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
  .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
  .pa_drive(pa_drive), .pa_dir(pa_dir),
  .a_flag1(a_flag1), .a_flag2(a_flag2), .a_ctrl(a_ctrl),
  .a_rd_pulse(a_rd_pulse), .b_rd_pulse(b_rd_pulse),
  .a_wr_pulse(a_wr_pulse), .b_wr_pulse(b_wr_pulse),
  .irq_a(irq_a)
);

// File: tb/ppi_regfile_tb_top.sv
`timescale 1ns/1ps
module ppi_regfile_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n = 1'b0, cs = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0] reg_sel = '0;
  logic [7:0] wdata = '0, pa_in = '0, pb_in = '0;
  logic       a_flag1 = 0, a_flag2 = 0, b_flag1 = 0, b_flag2 = 0;
  logic [7:0] rdata, pa_drive, pa_dir, pb_drive, pb_dir;
  logic [5:0] a_ctrl, b_ctrl;
  logic       a_rd_pulse, a_wr_pulse, b_rd_pulse, b_wr_pulse, irq_a, irq_b;

  ppi_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .cs(cs), .rd_en(rd_en), .wr_en(wr_en),
    .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata),
    .pa_in(pa_in), .pb_in(pb_in),
    .pa_drive(pa_drive), .pa_dir(pa_dir), .pb_drive(pb_drive), .pb_dir(pb_dir),
    .a_flag1(a_flag1), .a_flag2(a_flag2), .b_flag1(b_flag1), .b_flag2(b_flag2),
    .a_ctrl(a_ctrl), .b_ctrl(b_ctrl),
    .a_rd_pulse(a_rd_pulse), .a_wr_pulse(a_wr_pulse),
    .b_rd_pulse(b_rd_pulse), .b_wr_pulse(b_wr_pulse),
    .irq_a(irq_a), .irq_b(irq_b)
  );

  int checks = 0, errors = 0;
  logic [7:0] s_rd;
  logic       s_arp, s_awp, s_brp, s_bwp;

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL R%0d: got %02h expected %02h at %0t", req, got, exp, $time);
    end
  endtask

  // one bus cycle; combinational results snapped 2 ns after the falling edge
  task automatic bus(input logic rd, input logic wr, input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; rd_en = rd; wr_en = wr; reg_sel = s; wdata = d;
    #2;
    s_rd = rdata; s_arp = a_rd_pulse; s_awp = a_wr_pulse;
    s_brp = b_rd_pulse; s_bwp = b_wr_pulse;
    @(posedge clk); #1;
    cs = 1'b0; rd_en = 1'b0; wr_en = 1'b0;
  endtask

  typedef struct packed {
    logic       rd;
    logic [1:0] sel;
    logic [7:0] wd;
    logic [7:0] pin;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 8'h00, 8'hAA, 8'h00, 4'd1},  // R1: data loc reads direction 0x00
    '{1'b0, 2'd0, 8'hF0, 8'h00, 8'h00, 4'd2},  // R2: write direction A
    '{1'b1, 2'd0, 8'h00, 8'h00, 8'hF0, 4'd2},  // R2: reads direction back
    '{1'b0, 2'd2, 8'h04, 8'h00, 8'h00, 4'd2},  // R2: select output register
    '{1'b0, 2'd0, 8'h3C, 8'h00, 8'h00, 4'd3},  // R3: write output A
    '{1'b1, 2'd0, 8'h00, 8'hAA, 8'h3A, 4'd3},  // R3: merge with pins AA
    '{1'b1, 2'd0, 8'h00, 8'h55, 8'h35, 4'd3},  // R3: merge with pins 55
    '{1'b1, 2'd2, 8'h00, 8'h00, 8'h04, 4'd5},  // R5: control readback
    '{1'b0, 2'd2, 8'hFF, 8'h00, 8'h00, 4'd5},  // R5: top bits discarded
    '{1'b1, 2'd2, 8'h00, 8'h00, 8'h3F, 4'd5},  // R5: reads 3F
    '{1'b0, 2'd2, 8'h04, 8'h00, 8'h00, 4'd5},  // R5: restore
    '{1'b0, 2'd3, 8'h04, 8'h00, 8'h00, 4'd2},  // R2: select output B
    '{1'b0, 2'd1, 8'hA5, 8'h00, 8'h00, 4'd4},  // R4: write output B
    '{1'b1, 2'd1, 8'h00, 8'h0F, 8'h0F, 4'd3}   // R3: all-input port B reads pins
  };

  initial begin : watchdog
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(1, pa_drive, 8'h00); check(1, pa_dir, 8'h00);
    check(1, pb_drive, 8'h00); check(1, pb_dir, 8'h00);
    check(1, {6'b0, irq_b, irq_a}, 8'h00);
    check(10, rdata, 8'h00);  // R10: no strobe, bus idle

    for (int i = 0; i < NV; i++) begin
      pa_in = VEC[i].pin; pb_in = VEC[i].pin;
      bus(VEC[i].rd, ~VEC[i].rd, VEC[i].sel, VEC[i].wd);
      if (VEC[i].rd) check(int'(VEC[i].req), s_rd, VEC[i].exp);
    end

    // R4: drive masked by direction; later direction write retargets drive
    check(4, pa_drive, 8'h30);
    check(4, pb_drive, 8'h00);
    bus(1'b0, 1'b1, 2'd3, 8'h00);
    bus(1'b0, 1'b1, 2'd1, 8'h0F);
    check(4, pb_dir, 8'h0F);
    check(4, pb_drive, 8'h05);

    // R7/R8: pulses only on output register accesses
    bus(1'b1, 1'b0, 2'd1, 8'h00);   // port B now selects direction
    check(7, {s_arp, s_brp}, 2'b00);
    bus(1'b0, 1'b1, 2'd1, 8'h0F);
    check(8, {s_awp, s_bwp}, 2'b00);
    bus(1'b1, 1'b0, 2'd0, 8'h00);
    check(7, {s_arp, s_brp}, 2'b10);

    // R6: status bits qualified by line-2 direction
    a_flag1 = 1; a_flag2 = 1;
    bus(1'b1, 1'b0, 2'd2, 8'h00);
    check(6, s_rd, 8'hC4);
    bus(1'b0, 1'b1, 2'd2, 8'h24);
    bus(1'b1, 1'b0, 2'd2, 8'h00);
    check(6, s_rd, 8'hA4);

    // R9: interrupt equation
    a_flag2 = 0;
    bus(1'b0, 1'b1, 2'd2, 8'h05); check(9, {7'b0, irq_a}, 8'h01);
    bus(1'b0, 1'b1, 2'd2, 8'h04); check(9, {7'b0, irq_a}, 8'h00);
    a_flag1 = 0; a_flag2 = 1;
    bus(1'b0, 1'b1, 2'd2, 8'h0C); check(9, {7'b0, irq_a}, 8'h01);
    bus(1'b0, 1'b1, 2'd2, 8'h2C); check(9, {7'b0, irq_a}, 8'h00);
    check(9, {7'b0, irq_b}, 8'h00);
    a_flag2 = 0;

    // R11: same-cycle read and write at port A output
    bus(1'b0, 1'b1, 2'd2, 8'h00);
    bus(1'b0, 1'b1, 2'd0, 8'hFF);
    bus(1'b0, 1'b1, 2'd2, 8'h04);
    bus(1'b0, 1'b1, 2'd0, 8'h11);
    bus(1'b1, 1'b1, 2'd0, 8'h22);
    check(11, s_rd, 8'h11);
    check(8, {s_arp, s_awp, s_brp, s_bwp}, 8'h0C);  // R8 with R7 together
    bus(1'b1, 1'b0, 2'd0, 8'h00);
    check(11, s_rd, 8'h22);

    // R10: no chip select
    @(negedge clk);
    cs = 0; rd_en = 1; wr_en = 1; reg_sel = 2'd0; wdata = 8'h99;
    #2;
    check(10, rdata, 8'h00);
    check(10, {a_rd_pulse, a_wr_pulse, b_rd_pulse, b_wr_pulse}, 8'h00);
    @(posedge clk); #1;
    rd_en = 0; wr_en = 0;
    check(10, pa_drive, 8'h22);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule